// File: doc/BRIEF.md
# Banked Scratchpad with Bank-Conflict Replay

This block is the on-chip scratchpad that the threads of one block share. A single transaction carries a group of up to 16 lane requests; every lane has its own word address, write enable, write data and an active bit. The storage is split into word-interleaved banks. In every cycle each bank serves at most one lane, so all lanes that land in distinct banks finish together, while lanes that collide on a bank are replayed over further cycles until the whole group has been served.

The requester offers a group with a valid/ready handshake. Ready stays low while a group is being worked off, so a new group enters only once the last colliding lane of the previous one has been served. Completion is marked by a one-cycle done pulse, and the per-lane read data stays on the response bus until the next group is accepted.

Top module: `smem_banked`

## Requirements
- R1: Default storage is 16 banks of 256 rows of 32-bit words (16 KB). The 12-bit lane address is a word address: bits [3:0] select the bank and bits [11:4] select the row inside that bank. A value written to an address is later read back from the same address.
- R2: Each bank performs at most one access (one lane) per cycle.
- R3: A group whose active lanes all fall in different banks (for example unit-stride addresses or any one-to-one permutation of lanes onto banks) completes in one service cycle: done is high in the cycle after the first clock edge that follows acceptance.
- R4: Lanes that share a bank are served in ascending lane order, so within one group a later lane sees an earlier lane's write to the same word, and when several lanes write one word the highest-numbered lane's data remains.
- R5: A group needs as many service cycles as the largest number of active lanes mapped to one bank (minimum one); done appears that many clock edges after the acceptance edge.
- R6: Several lanes reading the identical word are not merged; they count as a bank conflict and are served one per cycle.
- R7: A lane whose active bit is 0 makes no access: it writes nothing, and its read-data field is zero when done is high. A group with no active lane completes in one service cycle with all read data zero.
- R8: req_ready is high whenever no group is in progress and low from the cycle after acceptance until the cycle in which done is high; a group is accepted only on a clock edge where req_valid and req_ready are both high.
- R9: rsp_done is high for exactly one cycle per accepted group.
- R10: rsp_rdata holds lane l's read data in bits [32l+31:32l]; a lane that writes returns zero. rsp_rdata stays unchanged while no group is in progress and none is being accepted.
- R11: During and directly after reset, req_ready is 1, rsp_done is 0 and rsp_rdata is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request group is offered |
| req_ready | output | 1 | The block can take a group this cycle |
| req_mask | input | 16 | Per-lane active bit |
| req_we | input | 16 | Per-lane write enable |
| req_addr | input | 192 | Per-lane 12-bit word address, lane l in bits [12l+11:12l] |
| req_wdata | input | 512 | Per-lane 32-bit write data, lane l in bits [32l+31:32l] |
| rsp_done | output | 1 | One-cycle pulse: the accepted group is complete |
| rsp_rdata | output | 512 | Per-lane 32-bit read data, lane l in bits [32l+31:32l] |

## Verification
On every cycle the assertions watch that no bank grants more than one lane, that ready drops after an acceptance and is back when done rises, that done never lasts two cycles, that the read data of inactive lanes is zero at completion, and that the response bus is frozen while idle. Whether the right lane wins a bank first, whether the replay takes exactly the worst bank's lane count, and whether stored data round-trips through the bank and row mapping can only be shown by the bench, which compares latency and read data against a sequential model over unit-stride, permuted, single-bank, same-word, masked and random groups.

// File: rtl/smem_pkg.sv
// Package: default sizing shared by the banked scratchpad and its checker.
// Assumes every count below is a power of two.
package smem_pkg;
    localparam int LANES_DEF = 16;
    localparam int BANKS_DEF = 16;
    localparam int DATA_W_DEF = 32;
    localparam int ROWS_DEF = 256;
endpackage

// File: rtl/smem_bank_arb.sv
// Module: per-bank lane picker. Among the lanes still pending whose bank
// index equals BANK_ID, grants the lowest-numbered one (one-hot or zero).
// Assumes lane bank indices are presented as a flat vector, lane 0 lowest.
module smem_bank_arb #(
    parameter int LANES = 16,
    parameter int BANK_W = 4,
    parameter int BANK_ID = 0
) (
    input  logic [LANES-1:0]        pend,
    input  logic [LANES*BANK_W-1:0] lane_bank,
    output logic [LANES-1:0]        gnt
);
    logic [LANES-1:0] hit;

    // Mark pending lanes that target this bank.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            hit[l] = pend[l] && (lane_bank[l*BANK_W +: BANK_W] == BANK_W'(BANK_ID));
        end
    end

    // Isolate the lowest set bit: ascending lane order wins.
    assign gnt = hit & (~hit + LANES'(1));
endmodule

// File: rtl/smem_bank_port.sv
// Module: steers the granted lane's row, write enable and write data onto
// one bank's single port. Assumes the grant vector is one-hot or zero.
module smem_bank_port #(
    parameter int LANES = 16,
    parameter int ROW_W = 8,
    parameter int DATA_W = 32
) (
    input  logic [LANES-1:0]        gnt,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*ROW_W-1:0]  lane_row,
    input  logic [LANES*DATA_W-1:0] lane_wd,
    output logic                    en,
    output logic                    we,
    output logic [ROW_W-1:0]        row,
    output logic [DATA_W-1:0]       wd
);
    // OR-select the fields of the single granted lane.
    always_comb begin
        we = 1'b0;
        row = '0;
        wd = '0;
        for (int l = 0; l < LANES; l++) begin
            if (gnt[l]) begin
                we  = we | lane_we[l];
                row = row | lane_row[l*ROW_W +: ROW_W];
                wd  = wd | lane_wd[l*DATA_W +: DATA_W];
            end
        end
        en = |gnt;
    end
endmodule

// File: rtl/smem_bank.sv
// Module: one single-port bank. Write on a clock edge when enabled,
// read combinationally from the addressed row. Contents are not reset.
module smem_bank #(
    parameter int ROWS = 256,
    parameter int DATA_W = 32,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd
);
    logic [DATA_W-1:0] mem [ROWS];

    // Store write data into the addressed row.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[row] <= wd;
        end
    end

    assign rd = mem[row];
endmodule

// File: rtl/smem_banked.sv
// Module: banked scratchpad with automatic bank-conflict replay.
// Latches one group of lane requests, serves one lane per bank per cycle
// (lowest lane first) and pulses done after the last lane is served.
// Assumes word addresses with the bank index in the low bits and
// power-of-two lane, bank and row counts.
module smem_banked #(
    parameter int LANES = smem_pkg::LANES_DEF,
    parameter int BANKS = smem_pkg::BANKS_DEF,
    parameter int DATA_W = smem_pkg::DATA_W_DEF,
    parameter int ROWS = smem_pkg::ROWS_DEF,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ROW_W = $clog2(ROWS),
    localparam int ADDR_W = BANK_W + ROW_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_mask,
    input  logic [LANES-1:0]        req_we,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES*DATA_W-1:0] req_wdata,
    output logic                    rsp_done,
    output logic [LANES*DATA_W-1:0] rsp_rdata
);
    logic                    busy_q;
    logic                    done_q;
    logic [LANES-1:0]        mask_q;
    logic [LANES-1:0]        pend_q;
    logic [LANES-1:0]        we_q;
    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES*DATA_W-1:0] wd_q;
    logic [LANES*DATA_W-1:0] rdata_q;

    logic [LANES*BANK_W-1:0] lane_bank;
    logic [LANES*ROW_W-1:0]  lane_row;
    logic [BANKS*LANES-1:0]  gnt_flat;
    logic [DATA_W-1:0]       bank_rd [BANKS];
    logic [LANES-1:0]        served;
    logic [LANES-1:0]        pend_next;
    logic                    accept;

    assign accept = req_valid && !busy_q;
    assign req_ready = !busy_q;
    assign rsp_done = done_q;
    assign rsp_rdata = rdata_q;

    // Split each latched lane address into bank index and row.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_bank[l*BANK_W +: BANK_W] = addr_q[l*ADDR_W +: BANK_W];
            lane_row[l*ROW_W +: ROW_W]    = addr_q[l*ADDR_W + BANK_W +: ROW_W];
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic              b_en;
        logic              b_we;
        logic [ROW_W-1:0]  b_row;
        logic [DATA_W-1:0] b_wd;

        smem_bank_arb #(
            .LANES(LANES), .BANK_W(BANK_W), .BANK_ID(b)
        ) u_arb (
            .pend(pend_q), .lane_bank(lane_bank),
            .gnt(gnt_flat[b*LANES +: LANES])
        );

        smem_bank_port #(
            .LANES(LANES), .ROW_W(ROW_W), .DATA_W(DATA_W)
        ) u_port (
            .gnt(gnt_flat[b*LANES +: LANES]), .lane_we(we_q),
            .lane_row(lane_row), .lane_wd(wd_q),
            .en(b_en), .we(b_we), .row(b_row), .wd(b_wd)
        );

        smem_bank #(
            .ROWS(ROWS), .DATA_W(DATA_W)
        ) u_bank (
            .clk(clk), .en(b_en), .we(b_we), .row(b_row), .wd(b_wd),
            .rd(bank_rd[b])
        );
    end

    // Collect which lanes were granted by any bank this cycle.
    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) begin
            served = served | gnt_flat[b*LANES +: LANES];
        end
        pend_next = pend_q & ~served;
    end

    // Group state: accept, replay pending lanes, capture reads, flag done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            mask_q  <= '0;
            pend_q  <= '0;
            we_q    <= '0;
            addr_q  <= '0;
            wd_q    <= '0;
            rdata_q <= '0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
            mask_q  <= req_mask;
            pend_q  <= req_mask;
            we_q    <= req_we;
            addr_q  <= req_addr;
            wd_q    <= req_wdata;
            rdata_q <= '0;
        end else if (busy_q) begin
            pend_q <= pend_next;
            for (int l = 0; l < LANES; l++) begin
                if (served[l] && !we_q[l]) begin
                    rdata_q[l*DATA_W +: DATA_W] <= bank_rd[lane_bank[l*BANK_W +: BANK_W]];
                end
            end
            if (pend_next == '0) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                done_q <= 1'b0;
            end
        end else begin
            done_q <= 1'b0;
        end
    end
endmodule

// File: rtl/smem_banked_chk.sv
// Module: assertion checker for the banked scratchpad, bound to the top.
// Observes ports plus the per-bank grants and the latched active mask.
module smem_banked_chk #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic                    rsp_done,
    input logic [LANES*DATA_W-1:0] rsp_rdata,
    input logic [LANES-1:0]        mask_q,
    input logic [BANKS*LANES-1:0]  gnt_flat
);
    logic idle_zero_ok;

    // Inactive lanes must carry zero read data.
    always_comb begin
        idle_zero_ok = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            if (!mask_q[l] && (rsp_rdata[l*DATA_W +: DATA_W] != '0)) begin
                idle_zero_ok = 1'b0;
            end
        end
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank_chk
        // R2: one lane per bank per cycle
        p_one_lane_per_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_flat[b*LANES +: LANES]));
    end

    // R8: acceptance drops ready in the next cycle
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: ready is back when the group completes
    p_ready_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    // R9: done lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R7: inactive lanes return zero at completion
    p_inactive_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> idle_zero_ok);

    // R10: response frozen while idle with no acceptance
    p_hold_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(rsp_rdata));
endmodule

bind smem_banked smem_banked_chk #(
    .LANES(LANES), .BANKS(BANKS), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mask_q(mask_q),
    .gnt_flat(gnt_flat)
);

// File: tb/smem_banked_tb.sv
// Bench: directed corner cases plus seeded random groups, checked against
// a sequential lane-order model of the scratchpad.
module smem_banked_tb;
    localparam int L = 16;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int WORDS = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [L-1:0] req_mask = '0;
    logic [L-1:0] req_we = '0;
    logic [L*AW-1:0] req_addr = '0;
    logic [L*DW-1:0] req_wdata = '0;
    logic rsp_done;
    logic [L*DW-1:0] rsp_rdata;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [DW-1:0] ref_mem [WORDS];

    always #2 clk = ~clk;

    smem_banked u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fill_val(input int a);
        return (a * 32'h9E3779B1) ^ 32'h00C0FFEE;
    endfunction

    task automatic set_lane(input int l, input bit act, input bit wr,
                            input int a, input logic [DW-1:0] d);
        req_mask[l] = act;
        req_we[l] = wr;
        req_addr[l*AW +: AW] = AW'(a);
        req_wdata[l*DW +: DW] = d;
    endtask

    // Offer the staged group, wait for done, check latency, ready and data.
    task automatic run_group(input string req);
        int cnt [L];
        int k_exp;
        int cyc;
        bit rdy_ok;
        bit rd_ok;
        logic [DW-1:0] exp_rd [L];
        for (int b = 0; b < L; b++) cnt[b] = 0;
        k_exp = 1;
        for (int l = 0; l < L; l++) begin
            int a;
            a = int'(req_addr[l*AW +: AW]);
            exp_rd[l] = '0;
            if (req_mask[l]) begin
                cnt[a % 16]++;
                if (cnt[a % 16] > k_exp) k_exp = cnt[a % 16];
                if (req_we[l]) ref_mem[a] = req_wdata[l*DW +: DW];
                else exp_rd[l] = ref_mem[a];
            end
        end
        @(negedge clk);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        rdy_ok = 1;
        while (!rsp_done && cyc < 100) begin
            if (req_ready) rdy_ok = 0;
            @(negedge clk);
            cyc++;
        end
        chk(cyc == k_exp, req, "service cycles (R5)", cyc, k_exp);
        chk(rdy_ok, "R8", "ready low while serving", 1, 0);
        rd_ok = 1;
        for (int l = 0; l < L; l++) begin
            if (rsp_rdata[l*DW +: DW] !== exp_rd[l]) begin
                rd_ok = 0;
                $display("FAIL %s lane %0d rdata: actual %0h expected %0h",
                         req, l, rsp_rdata[l*DW +: DW], exp_rd[l]);
            end
        end
        n_tests++;
        if (!rd_ok) n_fail++;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [L*DW-1:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(req_ready == 1'b1, "R11", "ready in reset", req_ready, 1);
        chk(rsp_done == 1'b0, "R11", "done in reset", rsp_done, 0);
        chk(rsp_rdata == '0, "R11", "rdata in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);

        // R1, R3: fill every word with unit-stride write groups
        for (int g = 0; g < WORDS / L; g++) begin
            for (int l = 0; l < L; l++) set_lane(l, 1, 1, g*L + l, fill_val(g*L + l));
            run_group("R3");
        end

        // R1, R3: unit-stride read
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, 12'h100 + l, '0);
        run_group("R1");
        // R3: one-to-one permutation of lanes onto banks
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, 12'h230 + ((l*5 + 3) % 16), '0);
        run_group("R3");
        // R9: done is a single-cycle pulse
        @(negedge clk);
        chk(rsp_done == 1'b0, "R9", "done second cycle", rsp_done, 0);

        // R5: all lanes in bank 7, distinct rows -> 16 cycles
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, l*16 + 7, '0);
        run_group("R5");
        // R6: identical word read by all lanes -> 16 cycles, no merge
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, 12'h055, '0);
        run_group("R6");

        // R4: all lanes write one word; highest lane's data remains
        for (int l = 0; l < L; l++) set_lane(l, 1, 1, 12'h300, 32'hA000_0000 + l);
        run_group("R4");
        for (int l = 0; l < L; l++) set_lane(l, (l == 0), 0, 12'h300, '0);
        run_group("R4");
        chk(rsp_rdata[DW-1:0] == 32'hA000_000F, "R4", "last writer wins",
            rsp_rdata[DW-1:0], 32'hA000_000F);
        // R4: lane 1 reads old, lane 2 writes, lane 9 reads new (same bank)
        for (int l = 0; l < L; l++) set_lane(l, 0, 0, 0, '0);
        set_lane(1, 1, 0, 12'h3A5, '0);
        set_lane(2, 1, 1, 12'h3A5, 32'h5151_A2A2);
        set_lane(9, 1, 0, 12'h3A5, '0);
        run_group("R4");
        chk(rsp_rdata[9*DW +: DW] == 32'h5151_A2A2, "R4", "read after write lane 9",
            rsp_rdata[9*DW +: DW], 32'h5151_A2A2);

        // R7: masked-off writers leave memory untouched
        for (int l = 0; l < L; l++) set_lane(l, (l >= 4 && l < 8), 1, 12'h400 + l, 32'hDEAD_0000 + l);
        run_group("R7");
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, 12'h400 + l, '0);
        run_group("R7");
        chk(rsp_rdata[0 +: DW] == fill_val(12'h400), "R7", "inactive lane 0 no write",
            rsp_rdata[0 +: DW], fill_val(12'h400));
        // R7: empty group, one cycle, zero data
        for (int l = 0; l < L; l++) set_lane(l, 0, 0, l, 32'hFFFF_FFFF);
        run_group("R7");
        chk(rsp_rdata == '0, "R7", "empty group rdata", 0, 0);

        // R10: response held while idle
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, 12'h777 - l, '0);
        run_group("R10");
        held = rsp_rdata;
        repeat (4) @(negedge clk);
        chk(rsp_rdata == held, "R10", "rdata held idle", 0, 0);

        // R1, R4, R5: seeded random groups with conflict-prone addressing
        for (int t = 0; t < 400; t++) begin
            int mode;
            int base;
            int stride;
            mode = int'($urandom % 3);
            base = int'($urandom % WORDS);
            stride = 1 + int'($urandom % 8);
            for (int l = 0; l < L; l++) begin
                int a;
                if (mode == 0) a = int'($urandom % WORDS);
                else if (mode == 1) a = (base + l*stride) % WORDS;
                else a = (base + 16 * int'($urandom % 4)) % WORDS;
                set_lane(l, ($urandom % 4) != 0, ($urandom % 2) == 1, a, $urandom);
            end
            run_group("R5");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule